// File: doc/BRIEF.md
# Masked Vector Bit Counting Unit

This block takes a 512-bit source vector and, in every element at once, counts either the leading zero bits or the set bits. Elements are 32 bits wide, giving sixteen of them, or 64 bits wide, giving eight. Each count is placed zero-extended in the low bits of its own element.

A per-element write mask decides which elements receive their count. A clear mask bit either zeroes the element or copies the matching element of a pass-through vector, depending on the selected mode. The unit registers its result. It accepts a new operation on every cycle in which `in_valid` is high, and presents the result one cycle later with `out_valid`.

Inside, each 32-bit lane computes both counts. In 64-bit mode, a pair-merge stage joins the counts of two neighbouring lanes. A final lane writer then applies the mask and the mode.

Top module: `vbc_unit`

## Requirements
- R1: With `op_sel`=1 (population count) and `elem_wide`=0, element i (bits 32i+31..32i, i=0..15) receives the number of one bits in the source element.
- R2: With `op_sel`=1 and `elem_wide`=1, element j (bits 64j+63..64j, j=0..7) receives the number of one bits in the 64-bit source element, up to 64.
- R3: With `op_sel`=0 (leading-zero count) and `elem_wide`=0, each 32-bit element receives the number of zero bits above its highest set bit. An all-zero element gives 32.
- R4: With `op_sel`=0 and `elem_wide`=1, each 64-bit element receives its leading-zero count. An all-zero element gives 64.
- R5: A written count sits in the low bits of its element, and every higher bit of that element is 0.
- R6: With `elem_wide`=0, `mask[i]`=1 writes the count into element i.
- R7: With `elem_wide`=1, `mask[j]` for j=0..7 controls element j, and `mask[15:8]` has no effect.
- R8: With `zero_mode`=0 (merge), an element whose mask bit is 0 takes the matching bits of `pass_vec`.
- R9: With `zero_mode`=1, an element whose mask bit is 0 becomes all zeros.
- R10: The result of an operation accepted on a rising edge with `in_valid`=1 appears after that edge, with `out_valid`=1 for one cycle. Operations on consecutive cycles each produce a result on consecutive cycles. When `in_valid`=0, `out_valid` goes low after the edge.
- R11: After a synchronous active-low reset, `out_valid`=0 and `out_vec`=0. While `in_valid`=0, `out_vec` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 leading-zero count, 1 population count |
| elem_wide | input | 1 | 0 for 32-bit elements, 1 for 64-bit elements |
| zero_mode | input | 1 | 1 zeroes unmasked elements, 0 merges from pass_vec |
| mask | input | 16 | Per-element write enables |
| src_vec | input | 512 | Vector whose elements are counted |
| pass_vec | input | 512 | Merge source for unmasked elements |
| out_valid | output | 1 | Result valid |
| out_vec | output | 512 | Registered result vector |

## Verification
Random source lanes are shifted right by random amounts, so leading-zero counts cover the whole range 0 to 32. Empty upper halves then show whether the 64-bit merge carries into the lower lane. Directed all-zero and all-one vectors reach the extreme counts, 32 and 64, which would expose a count field that is one bit too narrow. Masks of all zeros, alternating bits and only the upper byte tell the merge mode from the zero mode, and show whether 64-bit mode wrongly reads `mask[15:8]`. Stretches with the strobe low, placed between back-to-back operations, separate the valid timing from the register hold.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    parameter int unsigned LANE_W = 32;
    localparam int unsigned CNT_W  = $clog2(LANE_W) + 1;
    localparam int unsigned PAIR_W = CNT_W + 1;

    typedef logic [CNT_W-1:0]  lane_cnt_t;
    typedef logic [PAIR_W-1:0] pair_cnt_t;

    typedef enum logic {
        OP_LZC = 1'b0,
        OP_POP = 1'b1
    } count_op_e;
endpackage

// File: rtl/vbc_lane_count.sv
module vbc_lane_count
    import vbc_pkg::*;
(
    input  logic [LANE_W-1:0] lane_data,
    output lane_cnt_t         ones_cnt,
    output lane_cnt_t         lead_cnt
);
    always_comb begin
        ones_cnt = '0;
        for (int b = 0; b < LANE_W; b++) begin
            ones_cnt = ones_cnt + lane_cnt_t'(lane_data[b]);
        end
    end

    logic hit_one;
    always_comb begin
        lead_cnt = '0;
        hit_one  = 1'b0;
        for (int b = LANE_W - 1; b >= 0; b--) begin
            if (lane_data[b]) begin
                hit_one = 1'b1;
            end else if (!hit_one) begin
                lead_cnt = lead_cnt + lane_cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/vbc_pair_merge.sv
module vbc_pair_merge
    import vbc_pkg::*;
(
    input  lane_cnt_t lo_ones,
    input  lane_cnt_t hi_ones,
    input  lane_cnt_t lo_lead,
    input  lane_cnt_t hi_lead,
    output pair_cnt_t pair_ones,
    output pair_cnt_t pair_lead
);
    localparam lane_cnt_t FULL_LANE = lane_cnt_t'(LANE_W);

    always_comb begin
        pair_ones = pair_cnt_t'(lo_ones) + pair_cnt_t'(hi_ones);
        if (hi_lead == FULL_LANE) begin
            pair_lead = pair_cnt_t'(FULL_LANE) + pair_cnt_t'(lo_lead);
        end else begin
            pair_lead = pair_cnt_t'(hi_lead);
        end
    end
endmodule

// File: rtl/vbc_lane_writer.sv
module vbc_lane_writer
    import vbc_pkg::*;
(
    input  logic [LANE_W-1:0] count_val,
    input  logic [LANE_W-1:0] pass_val,
    input  logic              lane_en,
    input  logic              zero_mode,
    output logic [LANE_W-1:0] lane_out
);
    always_comb begin
        if (lane_en) begin
            lane_out = count_val;
        end else if (zero_mode) begin
            lane_out = '0;
        end else begin
            lane_out = pass_val;
        end
    end
endmodule

// File: rtl/vbc_unit.sv
module vbc_unit
    import vbc_pkg::*;
#(
    parameter int unsigned VEC_W = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               op_sel,
    input  logic               elem_wide,
    input  logic               zero_mode,
    input  logic [15:0]        mask,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   pass_vec,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec
);
    localparam int unsigned NLANES = VEC_W / LANE_W;
    localparam int unsigned NPAIRS = NLANES / 2;

    count_op_e op_kind;
    assign op_kind = count_op_e'(op_sel);

    lane_cnt_t ones_l [NLANES];
    lane_cnt_t lead_l [NLANES];
    pair_cnt_t ones_p [NPAIRS];
    pair_cnt_t lead_p [NPAIRS];
    logic [VEC_W-1:0] next_vec;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        vbc_lane_count cnt_i (
            .lane_data (src_vec[i*LANE_W +: LANE_W]),
            .ones_cnt  (ones_l[i]),
            .lead_cnt  (lead_l[i])
        );
    end

    for (genvar j = 0; j < NPAIRS; j++) begin : g_pair
        vbc_pair_merge mrg_i (
            .lo_ones   (ones_l[2*j]),
            .hi_ones   (ones_l[2*j+1]),
            .lo_lead   (lead_l[2*j]),
            .hi_lead   (lead_l[2*j+1]),
            .pair_ones (ones_p[j]),
            .pair_lead (lead_p[j])
        );
    end

    for (genvar i = 0; i < NLANES; i++) begin : g_write
        logic [LANE_W-1:0] narrow_val;
        logic [LANE_W-1:0] wide_val;
        logic [LANE_W-1:0] sel_val;
        logic              lane_en;

        always_comb begin
            narrow_val = '0;
            narrow_val[CNT_W-1:0] = (op_kind == OP_POP) ? ones_l[i] : lead_l[i];
        end

        if (i % 2 == 0) begin : g_even
            always_comb begin
                wide_val = '0;
                wide_val[PAIR_W-1:0] = (op_kind == OP_POP) ? ones_p[i/2] : lead_p[i/2];
            end
        end else begin : g_odd
            assign wide_val = '0;
        end

        assign sel_val = elem_wide ? wide_val : narrow_val;
        assign lane_en = elem_wide ? mask[i/2] : mask[i];

        vbc_lane_writer wr_i (
            .count_val (sel_val),
            .pass_val  (pass_vec[i*LANE_W +: LANE_W]),
            .lane_en   (lane_en),
            .zero_mode (zero_mode),
            .lane_out  (next_vec[i*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= next_vec;
            end
        end
    end
endmodule

// File: rtl/vbc_checks.sv
module vbc_checks
    import vbc_pkg::*;
#(
    parameter int unsigned VEC_W = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             op_sel,
    input logic             elem_wide,
    input logic             zero_mode,
    input logic [15:0]      mask,
    input logic [VEC_W-1:0] src_vec,
    input logic [VEC_W-1:0] pass_vec,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec)); // R11
    AST_LZC_NARROW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && !elem_wide && mask[0] && src_vec[LANE_W-1:0] == '0)
        |=> out_vec[LANE_W-1:0] == LANE_W'(LANE_W)); // R3
    AST_LZC_WIDE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && elem_wide && mask[0] && src_vec[2*LANE_W-1:0] == '0)
        |=> out_vec[2*LANE_W-1:0] == (2*LANE_W)'(2*LANE_W)); // R4
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !elem_wide && mask[0])
        |=> out_vec[LANE_W-1:CNT_W] == '0); // R5
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode && mask == 16'h0)
        |=> out_vec == '0); // R9
    AST_MERGE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mode && mask == 16'h0)
        |=> out_vec == $past(pass_vec)); // R8
    AST_WIDE_HIGH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_wide && zero_mode && mask[7:0] == 8'h0)
        |=> out_vec == '0); // R7
endmodule

bind vbc_unit vbc_checks #(.VEC_W(VEC_W)) chk_i (.*);

// File: tb/vbc_unit_tb_top.sv
`timescale 1ns/1ps
module vbc_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         op_sel;
    logic         elem_wide;
    logic         zero_mode;
    logic [15:0]  mask;
    logic [511:0] src_vec;
    logic [511:0] pass_vec;
    logic         out_valid;
    logic [511:0] out_vec;

    int checks = 0;
    int errors = 0;
    logic [511:0] last_out = '0;

    always #2 clk = ~clk;

    vbc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .elem_wide(elem_wide), .zero_mode(zero_mode), .mask(mask),
        .src_vec(src_vec), .pass_vec(pass_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [63:0] count_bits(input logic [63:0] v, input int w, input logic pop);
        int n = 0;
        bit seen = 0;
        for (int b = w - 1; b >= 0; b--) begin
            if (pop) begin
                if (v[b]) n++;
            end else begin
                if (v[b]) seen = 1;
                else if (!seen) n++;
            end
        end
        return 64'(n);
    endfunction

    function automatic logic [511:0] model(input logic op, input logic wide, input logic zm,
                                           input logic [15:0] m, input logic [511:0] s,
                                           input logic [511:0] p);
        logic [511:0] r = '0;
        if (wide) begin
            for (int e = 0; e < 8; e++) begin
                if (m[e]) r[e*64 +: 64] = count_bits(s[e*64 +: 64], 64, op);
                else if (!zm) r[e*64 +: 64] = p[e*64 +: 64];
            end
        end else begin
            for (int e = 0; e < 16; e++) begin
                if (m[e]) r[e*32 +: 32] = 32'(count_bits({32'h0, s[e*32 +: 32]}, 32, op));
                else if (!zm) r[e*32 +: 32] = p[e*32 +: 32];
            end
        end
        return r;
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // drive at a falling edge, let one rising edge capture, check at the next falling edge
    task automatic step(input logic v, input logic op, input logic wide, input logic zm,
                        input logic [15:0] m, input logic [511:0] s, input logic [511:0] p,
                        input string tag);
        logic [511:0] exp_vec;
        in_valid = v; op_sel = op; elem_wide = wide; zero_mode = zm;
        mask = m; src_vec = s; pass_vec = p;
        exp_vec = v ? model(op, wide, zm, m, s, p) : last_out;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== v) begin
            errors++;
            $display("FAIL R10 out_valid actual %0b expected %0b", out_valid, v);
        end
        checks++;
        if (out_vec !== exp_vec) begin
            errors++;
            for (int e = 0; e < 16; e++) begin
                if (out_vec[e*32 +: 32] !== exp_vec[e*32 +: 32]) begin
                    $display("FAIL %s lane %0d actual %h expected %h", tag, e,
                             out_vec[e*32 +: 32], exp_vec[e*32 +: 32]);
                    break;
                end
            end
        end
        last_out = exp_vec;
    endtask

    function automatic logic [511:0] rand_src();
        logic [511:0] r;
        for (int e = 0; e < 16; e++) begin
            int sh = int'($urandom % 40);
            r[e*32 +: 32] = (sh >= 32) ? 32'h0 : ($urandom >> sh);
        end
        return r;
    endfunction

    function automatic logic [511:0] rand_vec();
        logic [511:0] r;
        for (int e = 0; e < 16; e++) r[e*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [511:0] ones = '1;
        logic [511:0] pv;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; op_sel = 1'b0; elem_wide = 1'b0;
        zero_mode = 1'b0; mask = '0; src_vec = '0; pass_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R11 reset actual %0b/%h expected 0/0", out_valid, out_vec);
        end
        pv = rand_vec();
        // R3: all-zero narrow elements give 32
        step(1, 0, 0, 0, 16'hFFFF, '0, pv, "R3");
        // R4: all-zero wide elements give 64
        step(1, 0, 1, 0, 16'h00FF, '0, pv, "R4");
        // R1: all ones give 32 per narrow element
        step(1, 1, 0, 0, 16'hFFFF, ones, pv, "R1");
        // R2: all ones give 64 per wide element
        step(1, 1, 1, 1, 16'h00FF, ones, pv, "R2");
        // R4: only the lowest bit set gives 63
        step(1, 0, 1, 1, 16'h00FF, {8{64'h1}}, pv, "R4");
        // R5: counts with pass-through all ones, upper bits must still clear
        step(1, 1, 0, 0, 16'hFFFF, {16{32'h0000_0101}}, ones, "R5");
        // R6: alternating mask, zero mode
        step(1, 1, 0, 1, 16'h5555, rand_vec(), pv, "R6");
        // R7: upper mask byte has no effect in wide mode
        step(1, 1, 1, 1, 16'hFF00, ones, pv, "R7");
        step(1, 0, 1, 0, 16'hFF5A, rand_src(), pv, "R7");
        // R8: merge copies pass-through for clear mask
        step(1, 0, 0, 0, 16'h0000, rand_src(), pv, "R8");
        // R9: zero mode clears masked-off elements
        step(1, 0, 0, 1, 16'h0F0F, rand_src(), pv, "R9");
        // R11: idle cycles hold the previous result, R10 drops valid
        step(0, 1, 1, 1, 16'h0000, rand_vec(), rand_vec(), "R11");
        step(0, 0, 0, 0, 16'hFFFF, rand_vec(), rand_vec(), "R11");
        for (int k = 0; k < 300; k++) begin
            logic v  = ($urandom % 5) != 0;
            logic op = $urandom[0];
            logic wd = $urandom[0];
            logic zm = $urandom[0];
            string tg;
            if (!v) tg = "R11";
            else if (op && !wd) tg = "R1";
            else if (op && wd) tg = "R2";
            else if (!wd) tg = "R3";
            else tg = "R4";
            step(v, op, wd, zm, 16'($urandom), rand_src(), rand_vec(), tg);
        end
        finish_run();
    end
endmodule